// File: doc/BRIEF.md
# Statistics SRAM Arbiter

This block owns the single 16-bit port of an external statistics SRAM. Three clients compete for it: a runt end-of-packet update, a legal-length end-of-packet update, and management CPU accesses. Each counter is 32 bits wide and spans two adjacent 16-bit words. The block turns a (device, port, statistic) triple into a word address. It runs the two word cycles of a counter back to back so nothing can get between them. Packet updates use a read-modify-write and keep the SRAM until the new value is stored.

A CPU access starts with a one-cycle start pulse, which the block latches as a busy flag. The flag stays set until the access finishes, and a one-cycle completion pulse marks the end. A single read returns one 32-bit value. A single write stores one 16-bit word. A block read streams every per-port counter to the read-data outputs. Between counters the block read gives the SRAM back to the arbiter, so a waiting packet update can step in.

The SRAM is synchronous. Read data appears on `sram_rdata` in the cycle after the read is issued, and a write takes effect at the clock edge on which it is issued.

Top module: `stat_sram_arbiter`

## Requirements
- R1: When the SRAM is free and several clients wait, the runt update goes first, then the legal-length update, then the CPU access.
- R2: The SRAM word address is {device, port, offset}, with the offset in the low 5 bits and the port in the 4 bits above it. A counter occupies an even offset, which holds bits 31:16, and the next odd offset, which holds bits 15:0. Every 32-bit read is a high-word read followed on the next cycle by the low-word read of the same counter.
- R3: An accepted runt update adds 1 to the runt counter at offset 0x0C of its device and port.
- R4: An accepted legal-length update adds 1 to the frame counter (offset 0x00) and adds its octet count to the octet counter (offset 0x02). Both are read-modify-write sequences held without release, and a carry out of the low word reaches the high word.
- R5: A CPU single read pulses `rd_valid` for one cycle. On that cycle `rd_data` is {word[even], word[odd]} and `rd_idx` is the statistic select shifted right by one.
- R6: A CPU single write stores `cpu_wdata` into exactly the one word addressed by the device, port and 5-bit statistic select, and leaves every other word unchanged.
- R7: A CPU block read returns counters 0 to 9 (offsets 0x00 to 0x12) in ascending `rd_idx` order. It ignores the statistic and write selects and writes nothing. It releases the SRAM after each counter, so an update that arrives meanwhile is written before the block read ends.
- R8: `cpu_go` while idle sets `cpu_busy` on the next cycle. Completion pulses `cpu_done` for one cycle in the same cycle that `cpu_busy` falls. `cpu_go` while busy is ignored.
- R9: Update requests that arrive while `mgmt_en` is low are discarded and change no counter.
- R10: Each update source holds at most one waiting request. A request from that source that arrives while one is already waiting is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Statistics gathering enable |
| runt_req | input | 1 | Runt update request |
| runt_dev | input | DEV_W | Device index of the runt update |
| runt_port | input | PORT_W | Port index of the runt update |
| pkt_req | input | 1 | Legal-length update request |
| pkt_dev | input | DEV_W | Device index of the legal-length update |
| pkt_port | input | PORT_W | Port index of the legal-length update |
| pkt_octets | input | OCT_W | Octet count to add |
| cpu_go | input | 1 | CPU access start pulse |
| cpu_block | input | 1 | 1 selects a block read |
| cpu_write | input | 1 | 1 selects a single write, 0 a single read |
| cpu_dev | input | DEV_W | CPU device index |
| cpu_port | input | PORT_W | CPU port index |
| cpu_stat | input | OFF_W | CPU statistic word offset |
| cpu_wdata | input | DW | CPU write word |
| cpu_busy | output | 1 | CPU access in progress |
| cpu_done | output | 1 | CPU access complete pulse |
| rd_valid | output | 1 | Read value valid pulse |
| rd_idx | output | OFF_W-1 | Counter index of the read value |
| rd_data | output | 2*DW | 32-bit read value |
| sram_cs | output | 1 | SRAM select |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | DEV_W+PORT_W+OFF_W | SRAM word address |
| sram_wdata | output | DW | SRAM write word |
| sram_rdata | input | DW | SRAM read word, one cycle after the read |

## Verification
The bench builds the block with DEV_W=2, which gives an 11-bit address. A full 2048-word SRAM image then fits in the bench, and it is compared word for word against an expected image after each scenario. All other parameters keep their defaults, so the ten-counter block read, the 12-port limit and the 16-bit carry into the high word all run at their real sizes. The 2-bit device field still leaves room for four devices, so updates can target one device while a block read walks another.

// File: rtl/stat_arb_pkg.sv
package stat_arb_pkg;

    typedef enum logic [1:0] {
        JOB_RUNT,
        JOB_PKT,
        JOB_CPU
    } job_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RHI,
        S_RLO,
        S_WLO,
        S_WHI,
        S_CAP,
        S_CWR
    } seq_e;

    localparam int OFF_FRAME = 'h00;
    localparam int OFF_OCTET = 'h02;
    localparam int OFF_RUNT  = 'h0C;

endpackage

// File: rtl/stat_req_slot.sv
module stat_req_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic         en,
    input  logic         take,
    input  logic [W-1:0] info_in,
    output logic         pend,
    output logic [W-1:0] info_q
);
    logic load;
    assign load = req && en && (!pend || take);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            info_q <= '0;
        end else begin
            if (load) begin
                pend   <= 1'b1;
                info_q <= info_in;
            end else if (take) begin
                pend <= 1'b0;
            end
        end
    end

    assert_full_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        (pend && !take) |=> (pend && $stable(info_q)));

    assert_off_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (!en && !pend) |=> !pend);
endmodule

// File: rtl/stat_prio_pick.sv
module stat_prio_pick #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         idle,
    input  logic [N-1:0] want,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (idle && want[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    assert_low_waits_R1: assert property (@(posedge clk) disable iff (rst)
        (gnt[N-1] |-> (want[N-2:0] == '0)));
endmodule

// File: rtl/stat_sram_arbiter.sv
module stat_sram_arbiter
    import stat_arb_pkg::*;
#(
    parameter int DEV_W    = 4,
    parameter int PORT_W   = 4,
    parameter int OFF_W    = 5,
    parameter int DW       = 16,
    parameter int OCT_W    = 16,
    parameter int NUM_CNT  = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mgmt_en,
    input  logic                          runt_req,
    input  logic [DEV_W-1:0]              runt_dev,
    input  logic [PORT_W-1:0]             runt_port,
    input  logic                          pkt_req,
    input  logic [DEV_W-1:0]              pkt_dev,
    input  logic [PORT_W-1:0]             pkt_port,
    input  logic [OCT_W-1:0]              pkt_octets,
    input  logic                          cpu_go,
    input  logic                          cpu_block,
    input  logic                          cpu_write,
    input  logic [DEV_W-1:0]              cpu_dev,
    input  logic [PORT_W-1:0]             cpu_port,
    input  logic [OFF_W-1:0]              cpu_stat,
    input  logic [DW-1:0]                 cpu_wdata,
    output logic                          cpu_busy,
    output logic                          cpu_done,
    output logic                          rd_valid,
    output logic [OFF_W-2:0]              rd_idx,
    output logic [2*DW-1:0]               rd_data,
    output logic                          sram_cs,
    output logic                          sram_we,
    output logic [DEV_W+PORT_W+OFF_W-1:0] sram_addr,
    output logic [DW-1:0]                 sram_wdata,
    input  logic [DW-1:0]                 sram_rdata
);
    localparam int AW     = DEV_W + PORT_W + OFF_W;
    localparam int IW     = OFF_W - 1;
    localparam int CW     = 2 * DW;
    localparam int RUNT_W = DEV_W + PORT_W;
    localparam int PKT_W  = DEV_W + PORT_W + OCT_W;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_CNT - 1);

    seq_e               st;
    job_e               job;
    logic [DEV_W-1:0]   j_dev;
    logic [PORT_W-1:0]  j_port;
    logic [OFF_W-1:0]   j_off;
    logic [CW-1:0]      j_inc;
    logic [OCT_W-1:0]   j_oct;
    logic               j_second;
    logic [DW-1:0]      hi_q, sum_hi_q;
    logic [CW-1:0]      sum;

    logic               c_block, c_write;
    logic [DEV_W-1:0]   c_dev;
    logic [PORT_W-1:0]  c_port;
    logic [OFF_W-1:0]   c_stat;
    logic [DW-1:0]      c_wdata;
    logic [IW-1:0]      c_idx;

    logic               runt_pend, pkt_pend;
    logic [RUNT_W-1:0]  runt_info;
    logic [PKT_W-1:0]   pkt_info;
    logic [2:0]         gnt;
    logic               idle;

    assign idle = (st == S_IDLE);

    stat_req_slot #(.W(RUNT_W)) i_runt_slot (
        .clk(clk), .rst(rst), .req(runt_req), .en(mgmt_en), .take(gnt[0]),
        .info_in({runt_dev, runt_port}), .pend(runt_pend), .info_q(runt_info)
    );

    stat_req_slot #(.W(PKT_W)) i_pkt_slot (
        .clk(clk), .rst(rst), .req(pkt_req), .en(mgmt_en), .take(gnt[1]),
        .info_in({pkt_dev, pkt_port, pkt_octets}), .pend(pkt_pend), .info_q(pkt_info)
    );

    stat_prio_pick #(.N(3)) i_pick (
        .clk(clk), .rst(rst), .idle(idle),
        .want({cpu_busy, pkt_pend, runt_pend}), .gnt(gnt)
    );

    assign sum = {hi_q, sram_rdata} + j_inc;

    always_ff @(posedge clk) begin
        rd_valid <= 1'b0;
        cpu_done <= 1'b0;
        if (rst) begin
            st       <= S_IDLE;
            job      <= JOB_CPU;
            j_dev    <= '0;
            j_port   <= '0;
            j_off    <= '0;
            j_inc    <= '0;
            j_oct    <= '0;
            j_second <= 1'b0;
            hi_q     <= '0;
            sum_hi_q <= '0;
            cpu_busy <= 1'b0;
            c_block  <= 1'b0;
            c_write  <= 1'b0;
            c_dev    <= '0;
            c_port   <= '0;
            c_stat   <= '0;
            c_wdata  <= '0;
            c_idx    <= '0;
            rd_idx   <= '0;
            rd_data  <= '0;
        end else begin
            if (cpu_go && !cpu_busy) begin
                cpu_busy <= 1'b1;
                c_block  <= cpu_block;
                c_write  <= cpu_write;
                c_dev    <= cpu_dev;
                c_port   <= cpu_port;
                c_stat   <= cpu_stat;
                c_wdata  <= cpu_wdata;
                c_idx    <= '0;
            end
            case (st)
                S_IDLE: begin
                    if (gnt[0]) begin
                        job    <= JOB_RUNT;
                        j_dev  <= runt_info[RUNT_W-1 -: DEV_W];
                        j_port <= runt_info[PORT_W-1:0];
                        j_off  <= OFF_W'(OFF_RUNT);
                        j_inc  <= CW'(1);
                        st     <= S_RHI;
                    end else if (gnt[1]) begin
                        job      <= JOB_PKT;
                        j_dev    <= pkt_info[PKT_W-1 -: DEV_W];
                        j_port   <= pkt_info[OCT_W +: PORT_W];
                        j_oct    <= pkt_info[OCT_W-1:0];
                        j_off    <= OFF_W'(OFF_FRAME);
                        j_inc    <= CW'(1);
                        j_second <= 1'b1;
                        st       <= S_RHI;
                    end else if (gnt[2]) begin
                        job    <= JOB_CPU;
                        j_dev  <= c_dev;
                        j_port <= c_port;
                        if (c_block) begin
                            j_off <= {c_idx, 1'b0};
                            st    <= S_RHI;
                        end else if (c_write) begin
                            j_off <= c_stat;
                            st    <= S_CWR;
                        end else begin
                            j_off <= {c_stat[OFF_W-1:1], 1'b0};
                            st    <= S_RHI;
                        end
                    end
                end
                S_RHI: st <= S_RLO;
                S_RLO: begin
                    hi_q <= sram_rdata;
                    st   <= (job == JOB_CPU) ? S_CAP : S_WLO;
                end
                S_WLO: begin
                    sum_hi_q <= sum[CW-1:DW];
                    st       <= S_WHI;
                end
                S_WHI: begin
                    if (j_second) begin
                        j_second <= 1'b0;
                        j_off    <= OFF_W'(OFF_OCTET);
                        j_inc    <= CW'(j_oct);
                        st       <= S_RHI;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                S_CAP: begin
                    rd_valid <= 1'b1;
                    rd_data  <= {hi_q, sram_rdata};
                    rd_idx   <= j_off[OFF_W-1:1];
                    st       <= S_IDLE;
                    if (c_block && c_idx != LAST_IDX) begin
                        c_idx <= c_idx + 1'b1;
                    end else begin
                        cpu_busy <= 1'b0;
                        cpu_done <= 1'b1;
                    end
                end
                S_CWR: begin
                    cpu_busy <= 1'b0;
                    cpu_done <= 1'b1;
                    st       <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        sram_cs    = 1'b0;
        sram_we    = 1'b0;
        sram_addr  = {j_dev, j_port, j_off};
        sram_wdata = '0;
        case (st)
            S_RHI: sram_cs = 1'b1;
            S_RLO: begin
                sram_cs      = 1'b1;
                sram_addr[0] = 1'b1;
            end
            S_WLO: begin
                sram_cs      = 1'b1;
                sram_we      = 1'b1;
                sram_addr[0] = 1'b1;
                sram_wdata   = sum[DW-1:0];
            end
            S_WHI: begin
                sram_cs    = 1'b1;
                sram_we    = 1'b1;
                sram_wdata = sum_hi_q;
            end
            S_CWR: begin
                sram_cs    = 1'b1;
                sram_we    = 1'b1;
                sram_wdata = c_wdata;
            end
            default: ;
        endcase
    end

    assert_read_pair_R2: assert property (@(posedge clk) disable iff (rst)
        (sram_cs && !sram_we && !sram_addr[0]) |=>
        (sram_cs && !sram_we && sram_addr == ($past(sram_addr) | AW'(1))));

    assert_write_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (sram_cs && sram_we && sram_addr[0] && job != JOB_CPU) |=>
        (sram_cs && sram_we && sram_addr == ($past(sram_addr) & ~AW'(1))));

    assert_done_clears_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !cpu_busy);

    assert_go_sets_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_go && !cpu_busy) |=> cpu_busy);

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/test_stat_sram_arbiter.sv
`timescale 1ns/100ps
module test_stat_sram_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mgmt_en = 1'b0;
    logic        runt_req = 1'b0, pkt_req = 1'b0;
    logic [1:0]  runt_dev = '0, pkt_dev = '0, cpu_dev = '0;
    logic [3:0]  runt_port = '0, pkt_port = '0, cpu_port = '0;
    logic [15:0] pkt_octets = '0, cpu_wdata = '0;
    logic        cpu_go = 1'b0, cpu_block = 1'b0, cpu_write = 1'b0;
    logic [4:0]  cpu_stat = '0;
    logic        cpu_busy, cpu_done, rd_valid;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        sram_cs, sram_we;
    logic [10:0] sram_addr;
    logic [15:0] sram_wdata;
    logic [15:0] sram_rdata = '0;

    int total = 0;
    int bad = 0;
    logic [15:0] mem [0:2047] = '{default: 16'h0};
    logic [15:0] gw  [0:2047] = '{default: 16'h0};
    logic [1:0]  cur_d = '0;
    logic [3:0]  cur_p = '0;
    logic [10:0] hi_log[$];
    logic [3:0]  blk_log[$];
    logic [31:0] last_rd = '0;
    int          done_cnt = 0;
    int          addr_bad = 0;
    logic [10:0] watch_addr = '1;
    logic        seen_watch = 1'b0;

    always #2.5 clk = ~clk;

    stat_sram_arbiter #(.DEV_W(2)) i_stat_sram_arbiter (
        .clk(clk), .rst(rst), .mgmt_en(mgmt_en),
        .runt_req(runt_req), .runt_dev(runt_dev), .runt_port(runt_port),
        .pkt_req(pkt_req), .pkt_dev(pkt_dev), .pkt_port(pkt_port), .pkt_octets(pkt_octets),
        .cpu_go(cpu_go), .cpu_block(cpu_block), .cpu_write(cpu_write),
        .cpu_dev(cpu_dev), .cpu_port(cpu_port), .cpu_stat(cpu_stat), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .rd_valid(rd_valid), .rd_idx(rd_idx),
        .rd_data(rd_data), .sram_cs(sram_cs), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    // synchronous SRAM model: one-cycle read latency
    always @(posedge clk) begin
        if (sram_cs && sram_we) mem[sram_addr] <= sram_wdata;
        if (sram_cs && !sram_we) sram_rdata <= mem[sram_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] wa(input logic [1:0] d, input logic [3:0] p, input logic [4:0] o);
        return {d, p, o};
    endfunction

    task automatic gadd(input logic [1:0] d, input logic [3:0] p, input logic [4:0] o, input logic [31:0] v);
        logic [10:0] a;
        logic [31:0] x;
        a = wa(d, p, o);
        x = {gw[a], gw[a | 11'd1]} + v;
        gw[a] = x[31:16];
        gw[a | 11'd1] = x[15:0];
    endtask

    // per-clock comparison against the expected image
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                logic [10:0] a;
                a = wa(cur_d, cur_p, {rd_idx, 1'b0});
                chk(rd_data == {gw[a], gw[a | 11'd1]}, "R5 R7 read value", rd_data, {gw[a], gw[a | 11'd1]});
                blk_log.push_back(rd_idx);
                last_rd = rd_data;
            end
            if (sram_cs && sram_addr[8:5] >= 4'd12) addr_bad++;
            if (sram_cs && !sram_we && !sram_addr[0]) hi_log.push_back(sram_addr);
            if (cpu_done) done_cnt++;
            if (sram_cs && sram_we && cpu_busy && sram_addr == watch_addr) seen_watch = 1'b1;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic runt(input logic [1:0] d, input logic [3:0] p, input int n);
        @(posedge clk); #1;
        runt_req = 1'b1; runt_dev = d; runt_port = p;
        cyc(n);
        runt_req = 1'b0;
    endtask

    task automatic pkt(input logic [1:0] d, input logic [3:0] p, input logic [15:0] oct);
        @(posedge clk); #1;
        pkt_req = 1'b1; pkt_dev = d; pkt_port = p; pkt_octets = oct;
        cyc(1);
        pkt_req = 1'b0;
    endtask

    task automatic cpu_start(input bit blk, input bit wr, input logic [1:0] d, input logic [3:0] p,
                             input logic [4:0] s, input logic [15:0] w);
        @(posedge clk); #1;
        cpu_go = 1'b1; cpu_block = blk; cpu_write = wr;
        cpu_dev = d; cpu_port = p; cpu_stat = s; cpu_wdata = w;
        if (!cpu_busy) begin
            cur_d = d; cur_p = p;
        end
        cyc(1);
        cpu_go = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (cpu_busy && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(!cpu_busy, "R8 access completes", {31'd0, cpu_busy}, 32'd0);
        cyc(2);
    endtask

    task automatic cpu_op(input bit blk, input bit wr, input logic [1:0] d, input logic [3:0] p,
                          input logic [4:0] s, input logic [15:0] w);
        cpu_start(blk, wr, d, p, s, w);
        wait_done();
    endtask

    task automatic check_mem(input string req);
        int diff;
        int first;
        diff = 0;
        first = -1;
        for (int i = 0; i < 2048; i++) begin
            if (mem[i] !== gw[i]) begin
                diff++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) first = 0;
        chk(diff == 0, req, {16'd0, mem[first]}, {16'd0, gw[first]});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_busy && !cpu_done && !rd_valid && !sram_cs, "R8 reset state",
            {28'd0, cpu_busy, cpu_done, rd_valid, sram_cs}, 32'd0);

        // R9: updates with statistics disabled are dropped
        runt(2'd1, 4'd3, 1);
        pkt(2'd1, 4'd3, 16'd64);
        cyc(20);
        check_mem("R9 disabled updates dropped");

        // R3: runt update
        mgmt_en = 1'b1;
        runt(2'd1, 4'd3, 1);
        gadd(2'd1, 4'd3, 5'h0C, 1);
        cyc(20);
        check_mem("R3 runt counter image");
        cpu_op(1'b0, 1'b0, 2'd1, 4'd3, 5'h0C, 16'h0);
        chk(last_rd == 32'd1, "R5 single read of runt counter", last_rd, 32'd1);

        // R6 then R4 with carry into the high word
        cpu_op(1'b0, 1'b1, 2'd2, 4'd5, 5'h01, 16'hFFFF);
        gw[wa(2'd2, 4'd5, 5'h01)] = 16'hFFFF;
        chk(mem[wa(2'd2, 4'd5, 5'h01)] == 16'hFFFF, "R6 single word write",
            {16'd0, mem[wa(2'd2, 4'd5, 5'h01)]}, 32'h0000FFFF);
        check_mem("R6 only one word written");
        cpu_op(1'b0, 1'b1, 2'd2, 4'd5, 5'h03, 16'hFFFE);
        gw[wa(2'd2, 4'd5, 5'h03)] = 16'hFFFE;
        pkt(2'd2, 4'd5, 16'd3);
        gadd(2'd2, 4'd5, 5'h00, 1);
        gadd(2'd2, 4'd5, 5'h02, 3);
        cyc(30);
        check_mem("R4 frame and octet image");
        chk({mem[wa(2'd2, 4'd5, 5'h00)], mem[wa(2'd2, 4'd5, 5'h01)]} == 32'h00010000,
            "R2 R4 carry into high word", {mem[wa(2'd2, 4'd5, 5'h00)], mem[wa(2'd2, 4'd5, 5'h01)]},
            32'h00010000);
        cpu_op(1'b0, 1'b0, 2'd2, 4'd5, 5'h02, 16'h0);
        chk(last_rd == 32'h00010001, "R5 read of octet counter", last_rd, 32'h00010001);

        // R1: all three clients arrive together
        hi_log.delete();
        @(posedge clk); #1;
        runt_req = 1'b1; runt_dev = 2'd0; runt_port = 4'd1;
        pkt_req = 1'b1; pkt_dev = 2'd0; pkt_port = 4'd2; pkt_octets = 16'd10;
        cpu_go = 1'b1; cpu_block = 1'b0; cpu_write = 1'b0;
        cpu_dev = 2'd0; cpu_port = 4'd4; cpu_stat = 5'h00;
        cur_d = 2'd0; cur_p = 4'd4;
        cyc(1);
        runt_req = 1'b0; pkt_req = 1'b0; cpu_go = 1'b0;
        gadd(2'd0, 4'd1, 5'h0C, 1);
        gadd(2'd0, 4'd2, 5'h00, 1);
        gadd(2'd0, 4'd2, 5'h02, 10);
        wait_done();
        chk(hi_log.size() == 4, "R1 number of counter accesses", hi_log.size(), 4);
        if (hi_log.size() == 4) begin
            chk(hi_log[0] == wa(2'd0, 4'd1, 5'h0C), "R1 runt first", hi_log[0], wa(2'd0, 4'd1, 5'h0C));
            chk(hi_log[1] == wa(2'd0, 4'd2, 5'h00), "R1 frame second", hi_log[1], wa(2'd0, 4'd2, 5'h00));
            chk(hi_log[2] == wa(2'd0, 4'd2, 5'h02), "R4 octet held in same update", hi_log[2], wa(2'd0, 4'd2, 5'h02));
            chk(hi_log[3] == wa(2'd0, 4'd4, 5'h00), "R1 cpu last", hi_log[3], wa(2'd0, 4'd4, 5'h00));
        end
        check_mem("R1 image after mixed burst");

        // R10: three back-to-back runt requests, one waits, one is lost
        runt(2'd3, 4'd7, 3);
        gadd(2'd3, 4'd7, 5'h0C, 2);
        cyc(30);
        check_mem("R10 one-deep queue");

        // R7: block read with ignored selects
        for (int i = 0; i < 10; i++) begin
            cpu_op(1'b0, 1'b1, 2'd1, 4'd3, 5'({i[3:0], 1'b1}), 16'h0100 + 16'(i));
            gw[wa(2'd1, 4'd3, 5'({i[3:0], 1'b1}))] = 16'h0100 + 16'(i);
        end
        blk_log.delete();
        cpu_op(1'b1, 1'b1, 2'd1, 4'd3, 5'h1F, 16'hDEAD);
        chk(blk_log.size() == 10, "R7 ten counters returned", blk_log.size(), 10);
        for (int i = 0; i < 10; i++) begin
            if (i < blk_log.size())
                chk(blk_log[i] == 4'(i), "R7 ascending order", blk_log[i], i);
        end
        check_mem("R7 block writes nothing");

        // R7 preemption and R8 go ignored while busy
        blk_log.delete();
        watch_addr = wa(2'd2, 4'd9, 5'h0C);
        seen_watch = 1'b0;
        done_cnt = 0;
        cpu_start(1'b1, 1'b0, 2'd1, 4'd3, 5'h00, 16'h0);
        cyc(5);
        runt(2'd2, 4'd9, 1);
        gadd(2'd2, 4'd9, 5'h0C, 1);
        cpu_start(1'b0, 1'b1, 2'd0, 4'd0, 5'h01, 16'hBEEF);
        wait_done();
        chk(seen_watch, "R7 update served during block read", {31'd0, seen_watch}, 32'd1);
        chk(blk_log.size() == 10, "R7 block completes after preemption", blk_log.size(), 10);
        chk(done_cnt == 1, "R8 single completion pulse", done_cnt, 1);
        check_mem("R8 go while busy ignored");

        chk(addr_bad == 0, "R2 port field in range", addr_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule